// File: doc/BRIEF.md
# Compare-Negative Immediate Flag Unit

This execute-stage unit looks at a 32-bit instruction word and detects the immediate form of compare-negative, in either the 32-bit or 64-bit operand width. For a recognised instruction it adds the source register value to a zero-extended 12-bit immediate. Before the add, the immediate may be moved up by 12 bit places. The unit keeps only the four condition flags from that add (negative, zero, carry, overflow). The sum itself is discarded and never reaches a register.

The register file is outside the block. The unit gives it the source register index as a pure decode of the instruction word, and the register file returns the operand in the same cycle. A recognised instruction raises a combinational match output. One clock later, the registered flags show the new value and a one-cycle write enable tells downstream state to take them.

Top module: `cmni_exec_unit`

## Requirements
- R1: `match_o` is high in a cycle exactly when `valid_i` is high, instruction bits 30:29 are `01`, bits 28:23 are `100010` and bits 4:0 are `11111`. Bit 31 does not affect matching.
- R2: `src_idx_o` always equals instruction bits 9:5.
- R3: The immediate is instruction bits 21:10, zero-extended. When bit 22 is 1 it is shifted left by 12 before the add, and when bit 22 is 0 it is used unshifted.
- R4: Flag N (bit 3 of `flags_o`) is the top bit of the sum at the selected width: bit 63 when instruction bit 31 is 1, bit 31 when it is 0.
- R5: Flag Z (bit 2) is 1 exactly when the sum at the selected width is zero.
- R6: Flag C (bit 1) is the unsigned carry out of the top bit of the selected width.
- R7: Flag V (bit 0) is 1 when both addends have the same sign at the selected width and the sum's sign differs from it.
- R8: In the 32-bit form, source bits 63:32 have no effect on the flags.
- R9: After a cycle with `match_o` high, the next cycle shows `flags_we_o` high and `flags_o` holding that instruction's flags.
- R10: After a cycle with `match_o` low (a non-matching instruction or `valid_i` low), the next cycle shows `flags_we_o` low and `flags_o` unchanged.
- R11: A synchronous active-high reset makes `flags_o` equal to `0000` and `flags_we_o` low at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction word is valid this cycle |
| src_val_i | input | 64 | Source operand returned by the register file |
| src_idx_o | output | 5 | Source register index sent to the register file |
| match_o | output | 1 | Valid compare-negative immediate detected |
| flags_we_o | output | 1 | Flag write enable, one cycle after a match |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The embedded assertions check the following on every cycle:
- the match-to-write-enable timing;
- that the flags hold after cycles without a match;
- the reset clear;
- that a match always carries the fixed destination field;
- that Z and N are never set together on a write.

Only the bench scenarios can show the arithmetic itself. This covers the flag values across operand widths, shifted and unshifted immediates, carries and overflows at both sign boundaries, and the 32-bit form ignoring the upper operand half. The bench compares these against a model computed separately, and it sweeps the opcode and destination fields to confirm that only the exact pattern matches.

// File: rtl/cmni_pkg.sv
package cmni_pkg;

   // Condition flag bundle, N in the most significant position
   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   localparam int unsigned FLAG_W      = 4;
   // Fixed field values that identify the instruction
   localparam logic [1:0]  OP_HI_VAL   = 2'b01;      // bits 30:29
   localparam logic [5:0]  OP_CLASS    = 6'b100010;  // bits 28:23
   localparam logic [4:0]  DEST_ZERO   = 5'b11111;   // bits 4:0

   // Field positions inside the instruction word
   localparam int unsigned POS_WIDE    = 31;
   localparam int unsigned POS_OPHI_LO = 29;
   localparam int unsigned POS_CLS_LO  = 23;
   localparam int unsigned POS_SHIFT   = 22;
   localparam int unsigned POS_IMM_LO  = 10;
   localparam int unsigned POS_RN_LO   = 5;
   localparam int unsigned POS_RD_LO   = 0;

endpackage

// File: rtl/cmni_decode.sv
module cmni_decode
   import cmni_pkg::*;
#(
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned IMM_W     = 12,
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic [INSTR_W-1:0]   instr,
   output logic                 hit,
   output logic                 wide,
   output logic                 shift_sel,
   output logic [IMM_W-1:0]     imm_raw,
   output logic [REG_IDX_W-1:0] rn
);

   localparam int unsigned IMM_HI = POS_IMM_LO + IMM_W - 1;
   localparam int unsigned RN_HI  = POS_RN_LO + REG_IDX_W - 1;

   if (INSTR_W != 32) begin : g_bad_instr_w
      $error("cmni_decode: instruction word must be 32 bits");
   end
   if (IMM_HI >= POS_SHIFT) begin : g_bad_imm_w
      $error("cmni_decode: immediate field overlaps the shift bit");
   end
   if (RN_HI >= POS_IMM_LO) begin : g_bad_rn_w
      $error("cmni_decode: register field overlaps the immediate");
   end

   logic op_hi_ok;
   logic class_ok;
   logic dest_ok;

   always_comb begin
      op_hi_ok  = (instr[POS_OPHI_LO +: 2] == OP_HI_VAL);
      class_ok  = (instr[POS_CLS_LO +: 6] == OP_CLASS);
      dest_ok   = (instr[POS_RD_LO +: 5] == DEST_ZERO);
      hit       = op_hi_ok & class_ok & dest_ok;
      wide      = instr[POS_WIDE];
      shift_sel = instr[POS_SHIFT];
      imm_raw   = instr[POS_IMM_LO +: IMM_W];
      rn        = instr[POS_RN_LO +: REG_IDX_W];
   end

endmodule

// File: rtl/cmni_imm_expand.sv
module cmni_imm_expand #(
   parameter int unsigned IMM_W     = 12,
   parameter int unsigned SHIFT_AMT = 12,
   parameter int unsigned DATA_W    = 64
) (
   input  logic [IMM_W-1:0]  imm_raw,
   input  logic              shift_sel,
   output logic [DATA_W-1:0] imm_ext
);

   localparam int unsigned SPAN = IMM_W + SHIFT_AMT;

   if (SPAN > DATA_W) begin : g_bad_span
      $error("cmni_imm_expand: shifted immediate exceeds data width");
   end

   logic [DATA_W-1:0] plain;

   always_comb begin
      plain   = {{(DATA_W-IMM_W){1'b0}}, imm_raw};
      imm_ext = shift_sel ? (plain << SHIFT_AMT) : plain;
   end

endmodule

// File: rtl/cmni_flag_lane.sv
module cmni_flag_lane
   import cmni_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output nzcv_t        flags
);

   if (W < 2) begin : g_bad_w
      $error("cmni_flag_lane: lane width too small");
   end

   logic [W:0]   sum_ext;
   logic [W-1:0] sum;

   always_comb begin
      sum_ext = {1'b0, opa} + {1'b0, opb};
      sum     = sum_ext[W-1:0];
      flags.n = sum[W-1];
      flags.z = (sum == '0);
      flags.c = sum_ext[W];
      flags.v = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
   end

endmodule

// File: rtl/cmni_exec_unit.sv
module cmni_exec_unit
   import cmni_pkg::*;
#(
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned NARROW_W  = 32,
   parameter int unsigned IMM_W     = 12,
   parameter int unsigned SHIFT_AMT = 12,
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [INSTR_W-1:0]   instr_i,
   input  logic                 valid_i,
   input  logic [DATA_W-1:0]    src_val_i,
   output logic [REG_IDX_W-1:0] src_idx_o,
   output logic                 match_o,
   output logic                 flags_we_o,
   output logic [FLAG_W-1:0]    flags_o
);

   localparam int unsigned N_LANES = 2;

   if (NARROW_W >= DATA_W) begin : g_bad_widths
      $error("cmni_exec_unit: narrow width must be below data width");
   end

   logic              dec_hit;
   logic              dec_wide;
   logic              dec_shift;
   logic [IMM_W-1:0]  dec_imm;
   logic [DATA_W-1:0] imm_ext;
   nzcv_t             lane_flags [N_LANES];
   nzcv_t             sel_flags;
   nzcv_t             flags_q;
   logic              we_q;

   cmni_decode #(
      .INSTR_W   (INSTR_W),
      .IMM_W     (IMM_W),
      .REG_IDX_W (REG_IDX_W)
   ) u_decode (
      .instr     (instr_i),
      .hit       (dec_hit),
      .wide      (dec_wide),
      .shift_sel (dec_shift),
      .imm_raw   (dec_imm),
      .rn        (src_idx_o)
   );

   cmni_imm_expand #(
      .IMM_W     (IMM_W),
      .SHIFT_AMT (SHIFT_AMT),
      .DATA_W    (DATA_W)
   ) u_imm (
      .imm_raw   (dec_imm),
      .shift_sel (dec_shift),
      .imm_ext   (imm_ext)
   );

   // Lane 0 works at the narrow width, lane 1 at the full width
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam int unsigned LW = (g == 0) ? NARROW_W : DATA_W;
      cmni_flag_lane #(.W(LW)) u_lane (
         .opa   (src_val_i[LW-1:0]),
         .opb   (imm_ext[LW-1:0]),
         .flags (lane_flags[g])
      );
   end

   always_comb begin
      match_o   = valid_i & dec_hit;
      sel_flags = dec_wide ? lane_flags[1] : lane_flags[0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
         we_q    <= 1'b0;
      end else begin
         we_q <= match_o;
         if (match_o) begin
            flags_q <= sel_flags;
         end
      end
   end

   assign flags_we_o = we_q;
   assign flags_o    = flags_q;

   // R1: a match always carries the fixed destination and a valid strobe
   p_match_fields_r1: assert property (@(posedge clk) disable iff (rst)
      match_o |-> (valid_i && instr_i[4:0] == 5'b11111 && instr_i[30:29] == 2'b01));

   // R9: write enable follows a match by one cycle
   p_we_after_match_r9: assert property (@(posedge clk) disable iff (rst)
      match_o |=> flags_we_o);

   // R10: no write enable and stable flags after a cycle without a match
   p_no_we_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !match_o |=> !flags_we_o);

   p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !match_o |=> $stable(flags_o));

   // R11: reset clears the flags and the enable at the next edge
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> (flags_o == 4'b0000 && !flags_we_o));

   // R4, R5: a zero sum can never have its top bit set
   p_zero_not_neg_r5: assert property (@(posedge clk) disable iff (rst)
      (flags_we_o && flags_o[2]) |-> !flags_o[3]);

endmodule

// File: tb/cmni_exec_unit_bench.sv
`timescale 1ns/1ps
module cmni_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_i = '0;
   logic        valid_i = 1'b0;
   logic [63:0] src_val_i = '0;
   logic [4:0]  src_idx_o;
   logic        match_o;
   logic        flags_we_o;
   logic [3:0]  flags_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cmni_exec_unit u_cmni_exec_unit (
      .clk        (clk),
      .rst        (rst),
      .instr_i    (instr_i),
      .valid_i    (valid_i),
      .src_val_i  (src_val_i),
      .src_idx_o  (src_idx_o),
      .match_o    (match_o),
      .flags_we_o (flags_we_o),
      .flags_o    (flags_o)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic sf, input logic sh,
                                      input logic [11:0] imm, input logic [4:0] rn);
      return {sf, 2'b01, 6'b100010, sh, imm, rn, 5'b11111};
   endfunction

   // Independent flag model {N,Z,C,V}
   function automatic logic [3:0] model(input logic sf, input logic [63:0] a,
                                        input logic [11:0] imm, input logic sh);
      logic [63:0] b;
      logic [64:0] s64;
      logic [32:0] s32;
      logic n, z, c, v;
      b = sh ? ({52'd0, imm} << 12) : {52'd0, imm};
      if (sf) begin
         s64 = {1'b0, a} + {1'b0, b};
         n = s64[63];
         z = (s64[63:0] == 64'd0);
         c = s64[64];
         v = (a[63] == b[63]) && (s64[63] != a[63]);
      end else begin
         s32 = {1'b0, a[31:0]} + {1'b0, b[31:0]};
         n = s32[31];
         z = (s32[31:0] == 32'd0);
         c = s32[32];
         v = (a[31] == b[31]) && (s32[31] != a[31]);
      end
      return {n, z, c, v};
   endfunction

   function automatic logic [63:0] op_val(input int i);
      case (i)
         0:  return 64'h0;
         1:  return 64'h1;
         2:  return 64'h7FFF_FFFF;
         3:  return 64'h8000_0000;
         4:  return 64'hFFFF_FFFF;
         5:  return 64'hFFFF_F001;
         6:  return 64'h7FFF_FFFF_FFFF_FFFF;
         7:  return 64'h8000_0000_0000_0000;
         8:  return 64'hFFFF_FFFF_FFFF_FFFF;
         9:  return 64'hFFFF_FFFF_FFFF_F001;
         10: return 64'hDEAD_BEEF_7FFF_F800;
         11: return 64'h1234_5678_FFFF_F000;
         12: return 64'hFFFF_FFFF_FF00_0000;
         13: return 64'h0000_0001_0000_0000;
         14: return 64'h7FFF_FFFF_FF00_1000;
         default: return 64'hA5A5_A5A5_5A5A_5A5A;
      endcase
   endfunction

   function automatic logic [11:0] imm_val(input int i);
      case (i)
         0: return 12'h000;
         1: return 12'h001;
         2: return 12'h7FF;
         3: return 12'h800;
         default: return 12'hFFF;
      endcase
   endfunction

   // Drive one instruction at a falling edge; check match and index, then the
   // registered outputs one clock later.
   task automatic issue(input logic [31:0] ins, input logic vld, input logic [63:0] src,
                        input logic exp_match, input logic [3:0] exp_flags, input string tag);
      @(negedge clk);
      instr_i   = ins;
      valid_i   = vld;
      src_val_i = src;
      #1;
      check({63'd0, match_o}, {63'd0, exp_match}, {"R1 match ", tag});
      check({59'd0, src_idx_o}, {59'd0, ins[9:5]}, {"R2 src index ", tag});
      @(negedge clk);
      check({63'd0, flags_we_o}, {63'd0, exp_match}, {"R9/R10 write enable ", tag});
      if (exp_match) begin
         check({63'd0, flags_o[3]}, {63'd0, exp_flags[3]}, {"R4 N ", tag});
         check({63'd0, flags_o[2]}, {63'd0, exp_flags[2]}, {"R5 Z ", tag});
         check({63'd0, flags_o[1]}, {63'd0, exp_flags[1]}, {"R6 C ", tag});
         check({63'd0, flags_o[0]}, {63'd0, exp_flags[0]}, {"R7 V ", tag});
      end else begin
         check({60'd0, flags_o}, {60'd0, exp_flags}, {"R10 hold ", tag});
      end
      valid_i = 1'b0;
   endtask

   initial begin
      logic [3:0] cur;
      // R11: reset state
      repeat (3) @(negedge clk);
      check({60'd0, flags_o}, 64'd0, "R11 reset flags");
      check({63'd0, flags_we_o}, 64'd0, "R11 reset enable");
      rst = 1'b0;
      cur = 4'b0000;

      // R1: sweep bits 31:22 with the fixed destination
      for (int t = 0; t < 1024; t++) begin
         logic [9:0] top;
         logic em;
         logic [31:0] ins;
         top = t[9:0];
         em  = (top[8:1] == 8'b01100010);
         ins = {top, 12'h005, 5'd3, 5'b11111};
         if (em) cur = model(top[9], 64'h10, 12'h005, top[0]);
         issue(ins, 1'b1, 64'h10, em, cur, "opcode sweep");
      end

      // R1: destination sweep, only 31 matches
      for (int rd = 0; rd < 32; rd++) begin
         logic [31:0] ins;
         logic em;
         ins = {1'b1, 2'b01, 6'b100010, 1'b0, 12'h3, 5'd7, rd[4:0]};
         em  = (rd == 31);
         if (em) cur = model(1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 12'h3, 1'b0);
         issue(ins, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, em, cur, "dest sweep");
      end

      // R4..R8: operand x immediate x shift x width sweep
      for (int o = 0; o < 16; o++) begin
         for (int m = 0; m < 5; m++) begin
            for (int sh = 0; sh < 2; sh++) begin
               for (int sf = 0; sf < 2; sf++) begin
                  logic [4:0] rn;
                  rn  = 5'((o * 5 + m) % 32);
                  cur = model(sf[0], op_val(o), imm_val(m), sh[0]);
                  issue(mk(sf[0], sh[0], imm_val(m), rn), 1'b1, op_val(o), 1'b1, cur,
                        "arith sweep");
               end
            end
         end
      end

      // R3: shifted immediate wraps 0xFFFFF000 to zero with carry
      issue(mk(1'b0, 1'b1, 12'h001, 5'd1), 1'b1, 64'hFFFF_F000, 1'b1, 4'b0110, "R3 shifted");
      // R3: the same immediate unshifted gives a negative non-zero sum
      issue(mk(1'b0, 1'b0, 12'h001, 5'd1), 1'b1, 64'hFFFF_F000, 1'b1, 4'b1000, "R3 plain");

      // R8: upper operand half ignored in the 32-bit form
      issue(mk(1'b0, 1'b0, 12'h001, 5'd2), 1'b1, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1, 4'b1001,
            "R8 upper set");
      issue(mk(1'b0, 1'b0, 12'h001, 5'd2), 1'b1, 64'h0000_0000_7FFF_FFFF, 1'b1, 4'b1001,
            "R8 upper clear");
      cur = 4'b1001;

      // R10: idle cycle with a matching word, then a wrong destination
      issue(mk(1'b1, 1'b0, 12'h000, 5'd0), 1'b0, 64'h0, 1'b0, cur, "R10 idle");
      issue({mk(1'b1, 1'b0, 12'h000, 5'd0)} & 32'hFFFF_FFE0, 1'b1, 64'h0, 1'b0, cur,
            "R10 wrong dest");

      // R11: reset during operation
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check({60'd0, flags_o}, 64'd0, "R11 mid-run flags");
      check({63'd0, flags_we_o}, 64'd0, "R11 mid-run enable");
      rst = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule